// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. Three comparator flags report whether the supply is above the normal operating level, above the write-protect level, and above the battery switchover level. The block resynchronises and debounces each flag. It then runs a five-state sequencer that decides when the memory may be accessed, when writes and outputs must be locked off, and when the backup battery carries the array.

The host's chip-enable and write strobes pass through this block on their way to the memory. When protection is active, both strobes are forced inactive combinationally. A write that is in progress therefore stops in the same cycle that protection rises.

A one-time freshness seal keeps the battery switch open from reset until the supply is first seen above the write-protect level. After power returns, access resumes only after a recovery interval, counted in clock cycles, during which the host keeps its chip enable inactive. The write-protect threshold variant is selected by a parameter, and its nominal value is reported on an output for the comparator trim.

Top module: `pfs_sequencer`

## Requirements
- R1: While reset is asserted, and right after it, the state code is 0 (sealed). In this state write-protect and output-disable are high, battery select is low, the seal flag is high, and both memory strobes are low.
- R2: In state POWERED (code 1), a filtered write-protect flag that goes low moves the block to PROTECTED (code 2) on the next edge. In PROTECTED, write-protect and output-disable are high and both memory strobes stay low whatever the host drives.
- R3: The memory write strobe is never high in a cycle in which write-protect is high, so a write in progress is cut off in the very cycle protection asserts.
- R4: In PROTECTED, a filtered switchover flag that goes low moves the block to ON_BATTERY (code 3), with battery select high. When the flag returns high, the block goes back to PROTECTED with battery select low.
- R5: Battery select stays low and the seal flag stays high until the filtered write-protect flag is first high. The seal flag then clears and does not set again until reset. While sealed, a low switchover flag does not select the battery.
- R6: POWERED is entered only from RECOVERING (code 4). With DEB_LEN=3 and REC_CYCLES=20, raising the operating flag in PROTECTED, with write-protect and switchover flags high and the host chip enable low, gives POWERED exactly 26 clock edges later.
- R7: A host chip enable that is active during RECOVERING restarts the recovery count.
- R8: If the filtered operating or write-protect flag goes low during RECOVERING, the block returns to PROTECTED.
- R9: Each flag passes two synchroniser flops and a filter that adopts a new level only after DEB_LEN consecutive differing samples. A level change therefore reaches the state 3+DEB_LEN edges after it reaches the port, and a pulse shorter than DEB_LEN cycles is ignored.
- R10: wp_level_mv_o gives the nominal protect threshold in millivolts: 4620 when TIGHT_TOL=1 and 4370 otherwise.
- R11: In POWERED, with the supply between the write-protect and operating levels (operating flag low, write-protect flag high), the block stays in POWERED and host strobes pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_op_i | input | 1 | Comparator: supply above operating level |
| sup_above_wp_i | input | 1 | Comparator: supply above write-protect level |
| sup_above_sw_i | input | 1 | Comparator: supply above battery switchover level |
| host_ce_i | input | 1 | Host chip enable, active high |
| host_we_i | input | 1 | Host write strobe, active high |
| mem_ce_o | output | 1 | Gated chip enable to the memory |
| mem_we_o | output | 1 | Gated write strobe to the memory |
| wr_protect_o | output | 1 | Write protection active |
| out_disable_o | output | 1 | Data bus drivers forced to high impedance |
| batt_sel_o | output | 1 | Battery switch closed onto the array |
| seal_intact_o | output | 1 | Freshness seal not yet broken |
| pwr_state_o | output | 3 | Sequencer state code |
| wp_level_mv_o | output | 13 | Nominal write-protect threshold in mV |

## Verification
The bench builds the block with DEB_LEN=3, REC_CYCLES=20 and TIGHT_TOL=1. With a short filter, a two-cycle glitch falls just below the adoption length. With a short recovery count, the exact edge on which POWERED is entered (26 edges after the operating flag rises) and a recovery restart by the host chip enable both occur within a few dozen cycles. The wide-tolerance threshold value is not built and is left to a second elaboration.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_SEALED    = 3'd0,
    ST_POWERED   = 3'd1,
    ST_PROTECTED = 3'd2,
    ST_ON_BATT   = 3'd3,
    ST_RECOVER   = 3'd4
  } pfs_state_e;

  localparam int FLAG_OP   = 0;
  localparam int FLAG_WP   = 1;
  localparam int FLAG_SW   = 2;
  localparam int NUM_FLAGS = 3;

  localparam int LEVEL_W = 13;

  function automatic logic [LEVEL_W-1:0] wp_level_mv(input bit tight);
    return tight ? LEVEL_W'(4620) : LEVEL_W'(4370);
  endfunction

endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter #(
  parameter int DEB_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

  logic          sync1, sync2, filt;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      filt  <= 1'b0;
      cnt   <= '0;
    end else begin
      sync1 <= raw_i;
      sync2 <= sync1;
      if (sync2 == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_LEN - 1)) begin
        filt <= sync2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign filt_o = filt;

  // R9: the filtered level cannot move while the synchronised input agrees with it
  p_hold_when_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == filt) |=> $stable(filt_o));

endmodule

// File: rtl/pfs_recovery_timer.sv
module pfs_recovery_timer #(
  parameter int REC_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (run_i) begin
      if (done_o) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end

  // R6: the recovery count never passes its final value
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/pfs_power_fsm.sv
module pfs_power_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_f_i,
  input  logic       wp_f_i,
  input  logic       sw_f_i,
  input  logic       host_ce_i,
  input  logic       rec_done_i,
  output logic       rec_clear_o,
  output logic       rec_run_o,
  output logic       seal_intact_o,
  output pfs_state_e state_o
);
  pfs_state_e state, nxt;
  logic       seal;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SEALED:    if (wp_f_i) nxt = ST_PROTECTED;
      ST_POWERED:   if (!wp_f_i) nxt = ST_PROTECTED;
      ST_PROTECTED: begin
        if (!sw_f_i)              nxt = ST_ON_BATT;
        else if (op_f_i && wp_f_i) nxt = ST_RECOVER;
      end
      ST_ON_BATT:   if (sw_f_i) nxt = ST_PROTECTED;
      ST_RECOVER: begin
        if (!op_f_i || !wp_f_i) nxt = ST_PROTECTED;
        else if (rec_done_i)    nxt = ST_POWERED;
      end
      default:      nxt = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SEALED;
      seal  <= 1'b1;
    end else begin
      state <= nxt;
      if (seal && wp_f_i) seal <= 1'b0;
    end
  end

  assign rec_run_o     = (state == ST_RECOVER) && op_f_i && !host_ce_i;
  assign rec_clear_o   = (state != ST_RECOVER) || host_ce_i;
  assign seal_intact_o = seal;
  assign state_o       = state;

  // R5: battery cannot be selected while the seal holds
  p_batt_after_seal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> (state != ST_ON_BATT));

  // R5: a broken seal stays broken
  p_seal_one_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !seal |=> !seal);

  // R6: normal access is entered only out of recovery
  p_power_via_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POWERED && $past(state) != ST_POWERED) |-> $past(state) == ST_RECOVER);

  // R2: losing the protect flag while powered locks the memory next cycle
  p_drop_protects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POWERED && !wp_f_i) |=> (state == ST_PROTECTED));

endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
  import pfs_pkg::*;
#(
  parameter int DEB_LEN    = 3,
  parameter int REC_CYCLES = 12_500_000,
  parameter bit TIGHT_TOL  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sup_above_op_i,
  input  logic                sup_above_wp_i,
  input  logic                sup_above_sw_i,
  input  logic                host_ce_i,
  input  logic                host_we_i,
  output logic                mem_ce_o,
  output logic                mem_we_o,
  output logic                wr_protect_o,
  output logic                out_disable_o,
  output logic                batt_sel_o,
  output logic                seal_intact_o,
  output logic [2:0]          pwr_state_o,
  output logic [LEVEL_W-1:0]  wp_level_mv_o
);
  logic [NUM_FLAGS-1:0] raw, filt;
  logic                 rec_clear, rec_run, rec_done;
  pfs_state_e           state;
  logic                 access_ok;

  assign raw[FLAG_OP] = sup_above_op_i;
  assign raw[FLAG_WP] = sup_above_wp_i;
  assign raw[FLAG_SW] = sup_above_sw_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pfs_flag_filter #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  pfs_recovery_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (rec_clear),
    .run_i   (rec_run),
    .done_o  (rec_done)
  );

  pfs_power_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_f_i        (filt[FLAG_OP]),
    .wp_f_i        (filt[FLAG_WP]),
    .sw_f_i        (filt[FLAG_SW]),
    .host_ce_i     (host_ce_i),
    .rec_done_i    (rec_done),
    .rec_clear_o   (rec_clear),
    .rec_run_o     (rec_run),
    .seal_intact_o (seal_intact_o),
    .state_o       (state)
  );

  assign access_ok     = (state == ST_POWERED);
  assign wr_protect_o  = !access_ok;
  assign out_disable_o = !access_ok;
  assign mem_ce_o      = host_ce_i && access_ok;
  assign mem_we_o      = host_we_i && access_ok;
  assign batt_sel_o    = (state == ST_ON_BATT);
  assign pwr_state_o   = state;
  assign wp_level_mv_o = wp_level_mv(TIGHT_TOL);

  // R4: battery select only ever opens or closes through the protected state
  p_batt_leaves_to_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(batt_sel_o) |-> (pwr_state_o == 3'd2));

endmodule

// File: tb/tb_pfs_sequencer.sv
module tb_pfs_sequencer;
  localparam int DEB  = 3;
  localparam int REC  = 20;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op = 1'b0, wp = 1'b0, sw = 1'b0, ce = 1'b0, we = 1'b0;
  logic        mem_ce, mem_we, prot, odis, bat, seal;
  logic [2:0]  st;
  logic [12:0] lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pfs_sequencer #(.DEB_LEN(DEB), .REC_CYCLES(REC), .TIGHT_TOL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .sup_above_op_i(op), .sup_above_wp_i(wp), .sup_above_sw_i(sw),
    .host_ce_i(ce), .host_we_i(we),
    .mem_ce_o(mem_ce), .mem_we_o(mem_we), .wr_protect_o(prot),
    .out_disable_o(odis), .batt_sel_o(bat), .seal_intact_o(seal),
    .pwr_state_o(st), .wp_level_mv_o(lvl)
  );

  // {op,wp,sw,ce,we, state[2:0], prot,bat,seal,mem_we,mem_ce}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b00011_000_10100,
    13'b00111_000_10100,
    13'b01100_010_10000,
    13'b11100_001_00000,
    13'b11111_001_00011,
    13'b01111_001_00011,
    13'b00111_010_10000,
    13'b00011_011_11000,
    13'b00100_010_10000,
    13'b00000_011_11000,
    13'b01100_010_10000,
    13'b11100_001_00000
  };

  function automatic string vec_req(input int i);
    case (i)
      3, 4, 11: return "R6";
      5:        return "R11";
      6:        return "R2";
      7, 8, 9:  return "R4";
      default:  return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "state", st, 0);
    chk("R1", "protect", prot, 1);
    chk("R1", "outdis", odis, 1);
    chk("R1", "batt", bat, 0);
    chk("R1", "seal", seal, 1);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "state after release", st, 0);

    for (int i = 0; i < NVEC; i++) begin
      {op, wp, sw, ce, we} = VEC[i][12:8];
      tick(32);
      chk(vec_req(i), "state", st, int'(VEC[i][7:5]));
      chk(vec_req(i), "protect", prot, VEC[i][4]);
      chk(vec_req(i), "outdis", odis, VEC[i][4]);
      chk(vec_req(i), "batt", bat, VEC[i][3]);
      chk(vec_req(i), "seal", seal, VEC[i][2]);
      chk(vec_req(i), "mem_we", mem_we, VEC[i][1]);
      chk(vec_req(i), "mem_ce", mem_ce, VEC[i][0]);
    end

    // R3 / R9: write in progress when the protect flag drops
    ce = 1'b1; we = 1'b1;
    tick(2);
    chk("R3", "write passes before drop", mem_we, 1);
    op = 1'b0; wp = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      if (prot) chk("R3", "we while protected", mem_we, 0);
      if (k == 5) chk("R9", "state before latency", st, 1);
      if (k == 6) chk("R9", "state at latency", st, 2);
    end
    ce = 1'b0; we = 1'b0;

    // R9: a glitch shorter than the filter length is ignored
    sw = 1'b0;
    tick(2);
    sw = 1'b1;
    tick(10);
    chk("R9", "glitch state", st, 2);
    chk("R9", "glitch batt", bat, 0);

    // R8: recovery aborted by loss of the operating flag
    op = 1'b1; wp = 1'b1;
    tick(10);
    chk("R8", "recovering", st, 4);
    op = 1'b0;
    tick(10);
    chk("R8", "aborted", st, 2);

    // R6: exact recovery length
    op = 1'b1;
    tick(25);
    chk("R6", "not yet powered", st, 4);
    tick(1);
    chk("R6", "powered on time", st, 1);

    // R7: host chip enable restarts recovery
    op = 1'b0; wp = 1'b0;
    tick(10);
    op = 1'b1; wp = 1'b1;
    tick(16);
    ce = 1'b1;
    tick(1);
    chk("R7", "ce gated in recovery", mem_ce, 0);
    ce = 1'b0;
    tick(15);
    chk("R7", "count restarted", st, 4);
    tick(15);
    chk("R7", "powered after restart", st, 1);

    // R10: threshold report
    chk("R10", "level mv", lvl, 4620);

    // R1: reset in the middle of operation
    ce = 1'b1; we = 1'b1;
    rst_n = 1'b0;
    tick(2);
    chk("R1", "state mid reset", st, 0);
    chk("R1", "seal mid reset", seal, 1);
    chk("R1", "mem_we mid reset", mem_we, 0);
    chk("R1", "batt mid reset", bat, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule